// File: doc/BRIEF.md
# Command-Driven Serial Block Transmitter

This block is the transmit half of a serial communications controller. A CPU fills a byte FIFO and drives the block with one-shot commands written to a three-bit command port. One command starts a block, one marks the end of the message, and one resets the transmitter. Bytes leave on a single serial line, least significant bit first, one bit for each pulse of an external baud tick. When nothing is being sent, the line rests at logic one.

The block asks for more data through a pool-ready interrupt. This interrupt fires once each time the FIFO fill level drops to 32 bytes or fewer, which leaves room for a 32-byte chunk. When the CPU gives the end-of-message command, the block drains every queued byte. If CRC generation is enabled it then appends a CRC-16, after which the line returns to idle. If the FIFO empties before the end-of-message command arrives, the block stops at the byte boundary, the line returns to idle and an underrun status bit is set. Status bits clear when read, and a mask vector decides which of them drive the interrupt line.

Top module: `sblk_tx`

## Requirements
- R1: While `rst` is high, `txd` is 1 and `isr_q` is 0.
- R2: No bit is serialized before a start command (`cmd_we` with `cmd[0]`=1). Written bytes and baud ticks leave `txd` at 1.
- R3: After a start command, each `baud_tick` cycle drives the next bit of the current byte onto `txd`, least significant bit first. `txd` changes only in a tick cycle or in a reset-command cycle.
- R4: Status bit `isr_q[0]` (pool ready) is set once when the FIFO level becomes 32 or lower. It is set again only after the level has risen above 32. It is never set while the level is above 32.
- R5: With `crc_en`=1, the bit after the last data bit of a block ended by end-of-message (`cmd[1]`) begins the CRC-16. The CRC uses polynomial 0x8005, is preset to 0 at start, and takes the data bits in line order. It is sent high byte first, each byte LSB first. The line is idle at the next tick.
- R6: With `crc_en`=0, the line goes idle at the tick after the last data bit of a block ended by end-of-message, and no underrun is flagged.
- R7: An end-of-message command given while bytes remain queued, even in the middle of a byte, is held. All queued bytes are sent before the CRC.
- R8: If the FIFO is empty at a byte boundary and no end-of-message command is pending, that tick drives `txd` to 1, ends the block and sets `isr_q[1]` (underrun).
- R9: A reset command (`cmd[2]`) has priority over the other commands. It drives `txd` to 1 on the next clock, aborts the block and empties the FIFO, so a later block carries only bytes written afterwards.
- R10: A cycle with `isr_rd` high clears `isr_q` at the next edge. `irq` is high when any bit of `isr_q` has a 0 in the same bit of `imr`.
- R11: The FIFO holds 64 bytes. A write made while it is full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | FIFO write strobe |
| wr_data | input | 8 | Byte to queue |
| cmd_we | input | 1 | Command write strobe |
| cmd | input | 3 | Command bits: [0] start, [1] end of message, [2] transmitter reset |
| crc_en | input | 1 | Append CRC at end of message |
| baud_tick | input | 1 | One-cycle bit-time enable |
| isr_rd | input | 1 | Status read; clears `isr_q` |
| imr | input | 2 | Interrupt mask, 1 blocks the matching status bit |
| isr_q | output | 2 | Status: [0] pool ready, [1] underrun |
| irq | output | 1 | Interrupt request |
| txd | output | 1 | Serial output, idle high |

## Verification
The assertions assume that `baud_tick` is a single-cycle pulse and that commands arrive as single-cycle strobes. They also assume that status reads do not fall in the cycle where a new event sets a bit. The bench drives each of these inputs for exactly one clock, between active edges, and it reads status only while the line is quiet. It also waits at least two clocks after the FIFO level crosses the threshold before sampling the pool-ready bit, because the level register and the status register each add one cycle.

// File: rtl/sblk_tx_pkg.sv
package sblk_tx_pkg;

    localparam int unsigned BYTE_W   = 8;
    localparam logic [15:0] CRC_POLY = 16'h8005;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_DATA,
        TX_CRC_HI,
        TX_CRC_LO
    } tx_state_e;

    // Bit order matches the cmd port: [2] reset, [1] eom, [0] start
    typedef struct packed {
        logic reset;
        logic eom;
        logic start;
    } tx_cmd_t;

    typedef struct packed {
        logic underrun;
        logic pool;
    } tx_isr_t;

    // Advance the CRC over one byte, taking bits in line order (LSB first)
    function automatic logic [15:0] crc16_step(input logic [15:0] c_in,
                                               input logic [BYTE_W-1:0] d);
        logic [15:0] c;
        logic        fb;
        c = c_in;
        for (int i = 0; i < BYTE_W; i++) begin
            fb = c[15] ^ d[i];
            c  = {c[14:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

endpackage

// File: rtl/sblk_tx_fifo.sv
module sblk_tx_fifo
    import sblk_tx_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned LW   = AW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              push,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              pop,
    output logic [BYTE_W-1:0] rdata,
    output logic [LW-1:0]     level,
    output logic              empty,
    output logic              full
);

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wp, rp;
    logic              do_push, do_pop;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign empty   = (level == '0);
    assign full    = (level == LW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_push) wp <= ptr_next(wp);
            if (do_pop)  rp <= ptr_next(rp);
            case ({do_push, do_pop})
                2'b10:   level <= level + LW'(1);
                2'b01:   level <= level - LW'(1);
                default: level <= level;
            endcase
        end
    end

endmodule

// File: rtl/sblk_tx_crc.sv
module sblk_tx_crc
    import sblk_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              upd,
    input  logic [BYTE_W-1:0] din,
    output logic [15:0]       crc
);

    always_ff @(posedge clk) begin
        if (rst || clr)
            crc <= '0;
        else if (upd)
            crc <= crc16_step(crc, din);
    end

endmodule

// File: rtl/sblk_tx_irq.sv
module sblk_tx_irq
    import sblk_tx_pkg::*;
#(
    parameter int unsigned LW  = 7,
    parameter int unsigned THR = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [LW-1:0] level,
    input  logic          underrun_evt,
    input  logic          rd,
    input  logic [1:0]    imr,
    output logic [1:0]    isr_q,
    output logic          irq
);

    tx_isr_t isr_r, evt;
    logic    armed;
    logic    low;

    assign low          = (level <= LW'(THR));
    assign evt.pool     = armed && low;
    assign evt.underrun = underrun_evt;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b1;
            isr_r <= '0;
        end else begin
            if (evt.pool)
                armed <= 1'b0;
            else if (!low)
                armed <= 1'b1;
            isr_r <= (rd ? tx_isr_t'('0) : isr_r) | evt;
        end
    end

    assign isr_q = isr_r;
    assign irq   = |(isr_r & ~imr);

endmodule

// File: rtl/sblk_tx_ser.sv
module sblk_tx_ser
    import sblk_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_we,
    input  logic [2:0]        cmd,
    input  logic              crc_en,
    input  logic              baud_tick,
    input  logic              fifo_empty,
    input  logic [BYTE_W-1:0] fifo_rdata,
    input  logic [15:0]       crc_val,
    output logic              pop,
    output logic              crc_clr,
    output logic              crc_upd,
    output logic              flush,
    output logic              underrun_evt,
    output logic              txd
);

    localparam int unsigned CW = $clog2(BYTE_W);

    tx_state_e         state;
    tx_cmd_t           c;
    logic [BYTE_W-1:0] sh;
    logic [CW-1:0]     bitcnt;
    logic              eom_pend, eom_eff, boundary, in_data;

    assign c        = cmd_we ? tx_cmd_t'(cmd) : tx_cmd_t'('0);
    assign eom_eff  = eom_pend || c.eom;
    assign boundary = (state != TX_IDLE) && baud_tick && (bitcnt == '0) && !c.reset;
    assign in_data  = boundary && (state == TX_DATA);

    always_comb begin
        pop          = in_data && !fifo_empty;
        crc_upd      = pop;
        underrun_evt = in_data && fifo_empty && !eom_eff;
        flush        = c.reset;
        crc_clr      = c.reset || ((state == TX_IDLE) && c.start);
    end

    always_ff @(posedge clk) begin
        if (rst || c.reset) begin
            state    <= TX_IDLE;
            txd      <= 1'b1;
            sh       <= '0;
            bitcnt   <= '0;
            eom_pend <= 1'b0;
        end else if (state == TX_IDLE) begin
            txd <= 1'b1;
            if (c.start) begin
                state    <= TX_DATA;
                bitcnt   <= '0;
                eom_pend <= c.eom;
            end
        end else begin
            if (c.eom) eom_pend <= 1'b1;
            if (baud_tick) begin
                if (bitcnt != '0) begin
                    txd    <= sh[0];
                    sh     <= {1'b0, sh[BYTE_W-1:1]};
                    bitcnt <= bitcnt - CW'(1);
                end else begin
                    case (state)
                        TX_DATA: begin
                            if (!fifo_empty) begin
                                txd    <= fifo_rdata[0];
                                sh     <= {1'b0, fifo_rdata[BYTE_W-1:1]};
                                bitcnt <= CW'(BYTE_W - 1);
                            end else if (eom_eff && crc_en) begin
                                txd    <= crc_val[8];
                                sh     <= {1'b0, crc_val[15:9]};
                                bitcnt <= CW'(BYTE_W - 1);
                                state  <= TX_CRC_HI;
                            end else begin
                                txd      <= 1'b1;
                                state    <= TX_IDLE;
                                eom_pend <= 1'b0;
                            end
                        end
                        TX_CRC_HI: begin
                            txd    <= crc_val[0];
                            sh     <= {1'b0, crc_val[7:1]};
                            bitcnt <= CW'(BYTE_W - 1);
                            state  <= TX_CRC_LO;
                        end
                        default: begin
                            txd      <= 1'b1;
                            state    <= TX_IDLE;
                            eom_pend <= 1'b0;
                        end
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/sblk_tx.sv
module sblk_tx
    import sblk_tx_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 64,
    parameter int unsigned POOL_THR   = 32,
    localparam int unsigned LW        = $clog2(FIFO_DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              cmd_we,
    input  logic [2:0]        cmd,
    input  logic              crc_en,
    input  logic              baud_tick,
    input  logic              isr_rd,
    input  logic [1:0]        imr,
    output logic [1:0]        isr_q,
    output logic              irq,
    output logic              txd
);

    logic              flush, pop, fifo_empty, fifo_full;
    logic [BYTE_W-1:0] fifo_rdata;
    logic [LW-1:0]     fifo_level;
    logic              crc_clr, crc_upd, underrun_evt;
    logic [15:0]       crc_val;

    sblk_tx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (flush),
        .push  (wr_en),
        .wdata (wr_data),
        .pop   (pop),
        .rdata (fifo_rdata),
        .level (fifo_level),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    sblk_tx_crc u_crc (
        .clk (clk),
        .rst (rst),
        .clr (crc_clr),
        .upd (crc_upd),
        .din (fifo_rdata),
        .crc (crc_val)
    );

    sblk_tx_ser u_ser (
        .clk          (clk),
        .rst          (rst),
        .cmd_we       (cmd_we),
        .cmd          (cmd),
        .crc_en       (crc_en),
        .baud_tick    (baud_tick),
        .fifo_empty   (fifo_empty),
        .fifo_rdata   (fifo_rdata),
        .crc_val      (crc_val),
        .pop          (pop),
        .crc_clr      (crc_clr),
        .crc_upd      (crc_upd),
        .flush        (flush),
        .underrun_evt (underrun_evt),
        .txd          (txd)
    );

    sblk_tx_irq #(.LW(LW), .THR(POOL_THR)) u_irq (
        .clk          (clk),
        .rst          (rst),
        .level        (fifo_level),
        .underrun_evt (underrun_evt),
        .rd           (isr_rd),
        .imr          (imr),
        .isr_q        (isr_q),
        .irq          (irq)
    );

endmodule

// File: rtl/sblk_tx_chk.sv
module sblk_tx_chk #(
    parameter int unsigned LW    = 7,
    parameter int unsigned DEPTH = 64,
    parameter int unsigned THR   = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          cmd_rst,
    input logic          baud_tick,
    input logic [1:0]    imr,
    input logic [1:0]    isr_q,
    input logic          irq,
    input logic          txd,
    input logic [LW-1:0] fifo_level
);

    // R9
    reset_cmd_idles_line_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_rst |=> txd);

    // R3
    txd_moves_on_tick_only_chk: assert property (@(posedge clk) disable iff (rst)
        (!baud_tick && !cmd_rst) |=> $stable(txd));

    // R4
    pool_set_below_thr_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(isr_q[0]) |-> ($past(fifo_level) <= LW'(THR)));

    // R8
    underrun_line_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(isr_q[1]) |-> txd);

    // R10
    full_mask_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (imr == 2'b11) |-> !irq);

    // R11
    fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_level <= LW'(DEPTH));

endmodule

bind sblk_tx sblk_tx_chk #(.LW(LW), .DEPTH(FIFO_DEPTH), .THR(POOL_THR)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .cmd_rst    (cmd_we && cmd[2]),
    .baud_tick  (baud_tick),
    .imr        (imr),
    .isr_q      (isr_q),
    .irq        (irq),
    .txd        (txd),
    .fifo_level (fifo_level)
);

// File: tb/sblk_tx_tb_top.sv
module sblk_tx_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    // {crc_en, data byte}
    localparam logic [8:0] VEC [NVEC] = '{9'h1A5, 9'h000, 9'h1FF, 9'h0C3, 9'h101, 9'h180};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       cmd_we = 1'b0;
    logic [2:0] cmd = '0;
    logic       crc_en = 1'b0;
    logic       baud_tick = 1'b0;
    logic       isr_rd = 1'b0;
    logic [1:0] imr = '0;
    logic [1:0] isr_q;
    logic       irq;
    logic       txd;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sblk_tx dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .cmd_we(cmd_we), .cmd(cmd), .crc_en(crc_en), .baud_tick(baud_tick),
        .isr_rd(isr_rd), .imr(imr), .isr_q(isr_q), .irq(irq), .txd(txd)
    );

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input logic [15:0] c0, input logic [7:0] b);
        logic [15:0] c;
        c = c0;
        for (int i = 0; i < 8; i++) begin
            if (c[15] != b[i]) c = (c << 1) ^ 16'h8005;
            else               c = c << 1;
        end
        return c;
    endfunction

    task automatic do_cmd(input logic [2:0] c);
        @(negedge clk); cmd_we = 1'b1; cmd = c;
        @(negedge clk); cmd_we = 1'b0; cmd = '0;
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk); wr_en = 1'b1; wr_data = b;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic tick_bit(output logic b);
        @(negedge clk); baud_tick = 1'b1;
        @(negedge clk); baud_tick = 1'b0;
        b = txd;
    endtask

    task automatic get_byte(output logic [7:0] v);
        logic b;
        for (int i = 0; i < 8; i++) begin
            tick_bit(b);
            v[i] = b;
        end
    endtask

    task automatic read_isr(output logic [1:0] v);
        @(negedge clk); v = isr_q; isr_rd = 1'b1;
        @(negedge clk); isr_rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        report();
        $finish;
    end

    initial begin
        logic [7:0]  v, hi, lo;
        logic [1:0]  s;
        logic        b;
        logic [15:0] crc;
        int          zeros, bad;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 txd in reset", txd, 1);
        chk("R1 isr in reset", isr_q, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk("R4 pool after reset", isr_q, 2'b01);
        chk("R10 irq unmasked", irq, 1);
        read_isr(s);
        chk("R10 read value", s, 2'b01);
        chk("R10 cleared on read", isr_q, 0);

        // Vector table: single-byte blocks, R3 R5 R6
        for (int k = 0; k < NVEC; k++) begin
            push(VEC[k][7:0]);
            crc_en = VEC[k][8];
            do_cmd(3'b011);
            get_byte(v);
            chk("R3 data byte", v, VEC[k][7:0]);
            if (VEC[k][8]) begin
                get_byte(hi);
                get_byte(lo);
                chk("R5 crc", {hi, lo}, ref_crc(16'h0000, VEC[k][7:0]));
            end
            tick_bit(b);
            chk("R5 R6 idle after block", b, 1);
            read_isr(s);
            chk("R6 no underrun", s[1], 0);
        end

        // R2: no output before start
        push(8'h5A);
        push(8'h96);
        zeros = 0;
        for (int i = 0; i < 12; i++) begin
            tick_bit(b);
            if (b == 1'b0) zeros++;
        end
        chk("R2 line idle before start", zeros, 0);

        // R7: eom issued mid-byte while bytes still queued
        crc_en = 1'b1;
        do_cmd(3'b001);
        for (int i = 0; i < 4; i++) begin tick_bit(b); v[i] = b; end
        do_cmd(3'b010);
        for (int i = 4; i < 8; i++) begin tick_bit(b); v[i] = b; end
        chk("R7 first byte", v, 8'h5A);
        get_byte(v);
        chk("R7 second byte before crc", v, 8'h96);
        get_byte(hi);
        get_byte(lo);
        crc = ref_crc(ref_crc(16'h0000, 8'h5A), 8'h96);
        chk("R7 crc over both bytes", {hi, lo}, crc);
        tick_bit(b);
        chk("R7 idle after crc", b, 1);

        // R8 underrun with R10 mask
        crc_en = 1'b0;
        imr = 2'b10;
        push(8'hE7);
        do_cmd(3'b001);
        get_byte(v);
        chk("R8 byte before underrun", v, 8'hE7);
        tick_bit(b);
        chk("R8 line idle on underrun", b, 1);
        chk("R8 underrun flag", isr_q, 2'b10);
        chk("R10 masked irq low", irq, 0);
        imr = 2'b00;
        @(negedge clk);
        chk("R10 unmasked irq high", irq, 1);
        read_isr(s);

        // R4 threshold crossing
        for (int i = 0; i < 40; i++) push(8'h00);
        @(negedge clk);
        chk("R4 no pool above threshold", isr_q[0], 0);
        do_cmd(3'b001);
        for (int i = 0; i < 56; i++) tick_bit(b);
        chk("R4 level 33 no pool", isr_q[0], 0);
        tick_bit(b);
        @(negedge clk);
        chk("R4 pool at level 32", isr_q[0], 1);
        read_isr(s);
        for (int i = 0; i < 8; i++) tick_bit(b);
        @(negedge clk);
        chk("R4 once per crossing", isr_q[0], 0);
        tick_bit(b);
        tick_bit(b);
        chk("R9 mid-byte data zero", b, 0);

        // R9 reset command
        do_cmd(3'b100);
        chk("R9 line idle after reset", txd, 1);
        push(8'h3C);
        do_cmd(3'b011);
        get_byte(v);
        chk("R9 fifo flushed", v, 8'h3C);
        tick_bit(b);
        chk("R9 idle after block", b, 1);

        // R11 overflow writes dropped
        for (int i = 0; i < 70; i++) push(8'(i));
        do_cmd(3'b011);
        bad = 0;
        for (int k = 0; k < 64; k++) begin
            get_byte(v);
            if (v != 8'(k)) bad++;
        end
        chk("R11 64 bytes in order", bad, 0);
        tick_bit(b);
        chk("R11 extra writes dropped", b, 1);
        read_isr(s);
        chk("R11 no underrun", s[1], 0);

        report();
        $finish;
    end

endmodule